// File: doc/BRIEF.md
# Banked Secure Interrupt Controller

This block collects a large set of level-sensitive interrupt sources and presents them to a processor on two request lines: a normal request and a fast request. The sources are held in banks of 32. Each source has three control bits in its bank: an enable bit, a routing bit that picks the normal or the fast line, and a wakeup bit. Software reaches every control and status word through a plain 32-bit register port with separate write and read strobes.

The enable bits are never written directly. One register sets enable bits and a second register clears them, so software can change one source without a read-modify-write. A pending word per bank shows the enabled sources that are active. A separate wakeup line lets selected sources wake the system whether or not they are enabled. A holdoff register gives software a handshake before it powers down. Software writes a request, and the block accepts it only when no enabled source is pending at that moment. Three general configuration registers hold the values that software loads when it starts up.

Top module: `icx_top`

## Requirements
- R1: After reset every enable bit, every wakeup bit and the holdoff flag read 0, every routing bit reads 1, the three configuration registers read 0, and irq_o, fiq_o and wake_o are low.
- R2: Source n lives in bank n>>5 at bit n[4:0]. A write to 0x100+4*bank sets each enable bit whose data bit is 1 and leaves the bits whose data bit is 0 unchanged. A read of that address returns the bank's enable mask.
- R3: A write to 0x180+4*bank clears each enable bit whose data bit is 1, so all ones disables the whole bank. A read of that address also returns the enable mask.
- R4: The routing word at 0x080+4*bank is read/write. A routing bit of 1 sends the source to irq_o and a bit of 0 sends it to fiq_o.
- R5: irq_o is the registered OR over all sources of synchronized input AND enable AND routing bit. fiq_o is the same OR with the routing bit inverted. Each raw input passes two synchronizer flops, so a change at the input shows at the outputs on the third rising edge.
- R6: The read-only word at 0xD80+4*bank returns synchronized input AND enable for that bank. It follows the input level without latching, and writes to it have no effect.
- R7: The wakeup word at 0xE00+4*bank is read/write. wake_o is the registered OR over all sources of synchronized input AND wakeup bit, and it does not depend on the enable bits.
- R8: At 0x014, a write with bit 0 set makes the holdoff flag 1 only if no enabled source is pending in that cycle, and makes it 0 otherwise. A write with bit 0 clear makes the flag 0. A read returns the flag in bit 0.
- R9: The control word at 0x000 keeps all 32 bits, the mask at 0x00C keeps its low 8 bits, and the synchronizer setting at 0x010 keeps its low 2 bits. Each reads back what was written, so 0x80010001, 0x1F and 0x02 return unchanged.
- R10: Read data is registered and appears one cycle after rd_en_i. Unmapped addresses read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| src_i | input | 128 | Raw level interrupt sources, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 12 | Byte address of register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after rd_en_i |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| wake_o | output | 1 | Wakeup request |

## Verification
The assertions check on every cycle how the set and clear ports act on the enable mask. They check that the mask holds when neither port is written. They check that irq_o and fiq_o stay quiet when every enable is off, that wake_o stays quiet when no wakeup bit is set, and that the block refuses a holdoff request while an enabled source is pending. Only the bench's scenarios can show three things: the three-edge latency from a source pin to the outputs, the steering of one source between irq_o and fiq_o by its routing bit, and a wakeup source raising wake_o while it is disabled. The same holds for the pending word dropping back when the input falls, the holdoff flag being granted once the sources have gone quiet, and the configuration registers and unmapped addresses reading back as required.

// File: rtl/icx_pkg.sv
package icx_pkg;
  // Region codes taken from address bits [11:7]
  localparam logic [4:0] RG_MISC  = 5'h00;
  localparam logic [4:0] RG_ROUTE = 5'h01;
  localparam logic [4:0] RG_ENSET = 5'h02;
  localparam logic [4:0] RG_ENCLR = 5'h03;
  localparam logic [4:0] RG_PEND  = 5'h1B;
  localparam logic [4:0] RG_WAKE  = 5'h1C;
  // Offsets within the miscellaneous region, address bits [6:0]
  localparam logic [6:0] OFS_CTRL = 7'h00;
  localparam logic [6:0] OFS_MASK = 7'h0C;
  localparam logic [6:0] OFS_SYNC = 7'h10;
  localparam logic [6:0] OFS_HOLD = 7'h14;
endpackage

// File: rtl/icx_sync.sv
module icx_sync #(
  parameter int W = 128
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/icx_bank.sv
module icx_bank #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] src_i,
  input  logic         wr_route_i,
  input  logic         wr_set_i,
  input  logic         wr_clr_i,
  input  logic         wr_wake_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] en_o,
  output logic [W-1:0] route_o,
  output logic [W-1:0] wake_o,
  output logic [W-1:0] pend_o,
  output logic         irq_any_o,
  output logic         fiq_any_o,
  output logic         wake_any_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      en_o    <= '0;
      route_o <= '1;
      wake_o  <= '0;
    end else begin
      if (wr_set_i)      en_o <= en_o | wdata_i;
      else if (wr_clr_i) en_o <= en_o & ~wdata_i;
      if (wr_route_i)    route_o <= wdata_i;
      if (wr_wake_i)     wake_o  <= wdata_i;
    end
  end

  always_comb begin
    pend_o     = src_i & en_o;
    irq_any_o  = |(pend_o & route_o);
    fiq_any_o  = |(pend_o & ~route_o);
    wake_any_o = |(src_i & wake_o);
  end

  // R2: set bits appear in the mask
  assert_enable_set_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_set_i |=> ((en_o & $past(wdata_i)) == $past(wdata_i)));
  // R3: cleared bits leave the mask
  assert_enable_clear_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_clr_i && !wr_set_i) |=> ((en_o & $past(wdata_i)) == '0));
  // R2: mask holds without a set or clear write
  assert_enable_hold_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (!wr_set_i && !wr_clr_i) |=> $stable(en_o));
endmodule

// File: rtl/icx_top.sv
module icx_top #(
  parameter int NUM_BANKS = 4,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 12,
  parameter int MASK_W    = 8,
  parameter int SYNCC_W   = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_i,
  input  logic [NUM_BANKS*DATA_W-1:0]   src_i,
  input  logic                          wr_en_i,
  input  logic                          rd_en_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output logic [DATA_W-1:0]             rdata_o,
  output logic                          irq_o,
  output logic                          fiq_o,
  output logic                          wake_o
);
  import icx_pkg::*;

  localparam int NUM_SRC = NUM_BANKS * DATA_W;
  localparam int BIDX_W  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic [NUM_SRC-1:0]   src_sync;
  logic [4:0]           region;
  logic [4:0]           bsel;
  logic [6:0]           low7;
  logic                 bank_ok;
  logic [BIDX_W-1:0]    bidx;

  logic [DATA_W-1:0]    en_a    [NUM_BANKS];
  logic [DATA_W-1:0]    route_a [NUM_BANKS];
  logic [DATA_W-1:0]    wake_a  [NUM_BANKS];
  logic [DATA_W-1:0]    pend_a  [NUM_BANKS];
  logic [NUM_BANKS-1:0] irq_b, fiq_b, wake_b, pend_b, en_b, wcfg_b;

  logic [DATA_W-1:0]    ctrl_q;
  logic [MASK_W-1:0]    mask_q;
  logic [SYNCC_W-1:0]   syncc_q;
  logic                 hold_q;
  logic                 hold_wr;
  logic [DATA_W-1:0]    rd_val;

  icx_sync #(.W(NUM_SRC)) u_sync (
    .clk_i (clk_i), .rst_i (rst_i), .d_i (src_i), .q_o (src_sync)
  );

  always_comb begin
    region  = addr_i[11:7];
    bsel    = addr_i[6:2];
    low7    = addr_i[6:0];
    bidx    = bsel[BIDX_W-1:0];
    bank_ok = (int'(bsel) < NUM_BANKS) && (addr_i[1:0] == 2'b00);
    hold_wr = wr_en_i && (region == RG_MISC) && (low7 == OFS_HOLD);
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = wr_en_i && bank_ok && (bsel == 5'(b));

    icx_bank #(.W(DATA_W)) u_bank (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .src_i      (src_sync[b*DATA_W +: DATA_W]),
      .wr_route_i (hit && (region == RG_ROUTE)),
      .wr_set_i   (hit && (region == RG_ENSET)),
      .wr_clr_i   (hit && (region == RG_ENCLR)),
      .wr_wake_i  (hit && (region == RG_WAKE)),
      .wdata_i    (wdata_i),
      .en_o       (en_a[b]),
      .route_o    (route_a[b]),
      .wake_o     (wake_a[b]),
      .pend_o     (pend_a[b]),
      .irq_any_o  (irq_b[b]),
      .fiq_any_o  (fiq_b[b]),
      .wake_any_o (wake_b[b])
    );
    assign pend_b[b] = |pend_a[b];
    assign en_b[b]   = |en_a[b];
    assign wcfg_b[b] = |wake_a[b];
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ctrl_q  <= '0;
      mask_q  <= '0;
      syncc_q <= '0;
      hold_q  <= 1'b0;
      irq_o   <= 1'b0;
      fiq_o   <= 1'b0;
      wake_o  <= 1'b0;
      rdata_o <= '0;
    end else begin
      if (wr_en_i && region == RG_MISC) begin
        case (low7)
          OFS_CTRL: ctrl_q  <= wdata_i;
          OFS_MASK: mask_q  <= wdata_i[MASK_W-1:0];
          OFS_SYNC: syncc_q <= wdata_i[SYNCC_W-1:0];
          OFS_HOLD: hold_q  <= wdata_i[0] && !(|pend_b);
          default: ;
        endcase
      end
      irq_o   <= |irq_b;
      fiq_o   <= |fiq_b;
      wake_o  <= |wake_b;
      rdata_o <= rd_en_i ? rd_val : '0;
    end
  end

  always_comb begin
    rd_val = '0;
    if (region == RG_MISC) begin
      case (low7)
        OFS_CTRL: rd_val = ctrl_q;
        OFS_MASK: rd_val = {{(DATA_W-MASK_W){1'b0}}, mask_q};
        OFS_SYNC: rd_val = {{(DATA_W-SYNCC_W){1'b0}}, syncc_q};
        OFS_HOLD: rd_val = {{(DATA_W-1){1'b0}}, hold_q};
        default:  rd_val = '0;
      endcase
    end else if (bank_ok) begin
      case (region)
        RG_ROUTE:          rd_val = route_a[bidx];
        RG_ENSET, RG_ENCLR: rd_val = en_a[bidx];
        RG_PEND:           rd_val = pend_a[bidx];
        RG_WAKE:           rd_val = wake_a[bidx];
        default:           rd_val = '0;
      endcase
    end
  end

  // R5: no enabled source, no request on either line
  assert_quiet_when_disabled_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    !(|en_b) |=> (!irq_o && !fiq_o));
  // R7: no wakeup bit, no wakeup request
  assert_no_wake_unconfigured_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    !(|wcfg_b) |=> !wake_o);
  // R8: holdoff refused while an enabled source is pending
  assert_holdoff_refused_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (hold_wr && (|pend_b)) |=> !hold_q);
endmodule

// File: tb/test_icx_top.sv
module test_icx_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [127:0] src = '0;
  logic         wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0]  addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic         irq, fiq, wake;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #10 clk = ~clk;

  icx_top i_icx_top (
    .clk_i(clk), .rst_i(rst), .src_i(src), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_o(irq), .fiq_o(fiq), .wake_o(wake)
  );

  always @(posedge clk) rd_seen <= rd_en;

  // monitor: pops expected read data the cycle after each read
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if (rdata !== e) begin
        n_bad++;
        $display("FAIL %s: rdata actual %h expected %h", t, rdata, e);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    @(negedge clk); rd_en = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic chk(input string t, input logic act, input logic e);
    n_cmp++;
    if (act !== e) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", t, act, e);
    end
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq", irq, 1'b0); chk("R1 fiq", fiq, 1'b0); chk("R1 wake", wake, 1'b0);
    rd(12'h100, 32'h0, "R1 enable");
    rd(12'h08C, 32'hFFFF_FFFF, "R1 route");
    rd(12'hE0C, 32'h0, "R1 wakecfg");
    rd(12'h014, 32'h0, "R1 holdoff");
    rd(12'h000, 32'h0, "R1 ctrl");
    // R9 configuration registers
    wr(12'h000, 32'h8001_0001); wr(12'h00C, 32'h1F); wr(12'h010, 32'h02);
    rd(12'h000, 32'h8001_0001, "R9 ctrl");
    rd(12'h00C, 32'h1F, "R9 mask");
    rd(12'h010, 32'h02, "R9 sync");
    // R10 unmapped
    wr(12'h018, 32'hDEAD_BEEF);
    rd(12'h018, 32'h0, "R10 unmapped");
    // R2 set port
    wr(12'h100, 32'h0000_00F0); rd(12'h100, 32'h0000_00F0, "R2 set");
    wr(12'h100, 32'h0);         rd(12'h100, 32'h0000_00F0, "R2 zero no effect");
    wr(12'h100, 32'h1);         rd(12'h100, 32'h0000_00F1, "R2 set more");
    // R3 clear port
    wr(12'h180, 32'h10);        rd(12'h180, 32'h0000_00E1, "R3 clear bit");
    wr(12'h180, 32'hFFFF_FFFF); rd(12'h100, 32'h0, "R3 clear bank");
    // R5 source 37 = bank 1 bit 5, routed to normal line
    wr(12'h104, 32'h20);
    @(negedge clk); src[37] = 1'b1;
    repeat (2) @(negedge clk);
    chk("R5 latency irq low", irq, 1'b0);
    @(negedge clk);
    chk("R5 irq", irq, 1'b1); chk("R5 fiq", fiq, 1'b0);
    rd(12'hD84, 32'h20, "R6 pending");
    // R4 route to fast line
    wr(12'h084, 32'hFFFF_FFDF);
    @(negedge clk);
    chk("R4 irq", irq, 1'b0); chk("R4 fiq", fiq, 1'b1);
    rd(12'h084, 32'hFFFF_FFDF, "R4 route read");
    // R8 refused while pending
    wr(12'h014, 32'h1); rd(12'h014, 32'h0, "R8 refused");
    // R6 level follow
    @(negedge clk); src[37] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 fiq drop", fiq, 1'b0);
    rd(12'hD84, 32'h0, "R6 level drop");
    wr(12'h014, 32'h1); rd(12'h014, 32'h1, "R8 granted");
    wr(12'h014, 32'h0); rd(12'h014, 32'h0, "R8 cleared");
    // R6 write ignored
    wr(12'hD84, 32'hFFFF_FFFF);
    rd(12'hD84, 32'h0, "R6 write ignored");
    rd(12'h104, 32'h20, "R6 enable untouched");
    // R7 wakeup on disabled source 127
    wr(12'hE0C, 32'h8000_0000); rd(12'hE0C, 32'h8000_0000, "R7 wakecfg");
    @(negedge clk); src[127] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 wake", wake, 1'b1); chk("R7 irq", irq, 1'b0); chk("R7 fiq", fiq, 1'b0);
    rd(12'hD8C, 32'h0, "R6 disabled not pending");
    @(negedge clk); src[127] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 wake drop", wake, 1'b0);
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R10: actual %0d reads outstanding expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule